// File: doc/BRIEF.md
# Page permission restriction unit

This unit carries out a single command that narrows the access rights recorded in one entry of a protected-page map. A request presents a descriptor address, a target page address, descriptor flag bits (read, write, execute, and an indication that some reserved descriptor field is nonzero), the caller's privilege level, and the data already looked up for the target: whether the page address falls in the protected region, the map entry's state and permissions, the owning container's initialized flag, and whether another operation currently holds the page.

The unit evaluates its checks in a fixed priority order and reports exactly one result one cycle later. The result is a general-protection fault, a page fault, a soft status code that completes without a fault, or success. Only on success does it issue a write of the entry, with each permission bit ANDed with the matching descriptor bit and the restriction-in-progress bit set. Translation, the descriptor fetch and the map storage sit outside the unit and are reached through its ports.

Top module: `perm_restrict_unit`

## Requirements
- R1: A privilege level other than 0 gives outcome GP (code 1) regardless of every other input.
- R2: With privilege 0, a descriptor address whose low 6 bits are not all zero gives GP; otherwise a page address whose low 12 bits are not all zero gives GP.
- R3: After the alignment checks, a page address outside the protected region (region_hit=0) gives outcome PF (code 2).
- R4: After R3, a descriptor with the reserved indicator set, or with read=0 and write=1, gives GP.
- R5: After R4, an entry whose valid bit is 0 gives PF.
- R6: After R5, a page held by another operation gives outcome STATUS (code 3), status 1, zf=1 and no entry write; this takes precedence over R7.
- R7: After R6, an entry with its pending or modified bit set gives STATUS, status 2, zf=1 and no entry write.
- R8: After R7, an entry type other than 0 (the regular type) gives PF; after that, an uninitialized container gives GP.
- R9: When no check fires, the outcome is NONE (code 0), status 0, zf=0, ent_we=1, each written permission bit is the AND of the old bit and the descriptor bit, and the written restriction bit is 1.
- R10: arith_clr is 1 with every completion whose outcome is NONE or STATUS and 0 with every fault.
- R11: done is 0 in reset and pulses for one cycle in the cycle after each accepted request, with outcome, status, zf and arith_clr valid in that cycle.
- R12: A GP or PF outcome never comes with ent_we=1, and zf is 0 on faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe; all other inputs sampled with it |
| priv_lvl | input | 2 | Caller privilege level |
| desc_addr | input | ADDR_W | Descriptor address |
| page_addr | input | ADDR_W | Target page address |
| region_hit | input | 1 | Page address lies inside the protected region |
| desc_r | input | 1 | Descriptor read mask bit |
| desc_w | input | 1 | Descriptor write mask bit |
| desc_x | input | 1 | Descriptor execute mask bit |
| desc_rsvd_nz | input | 1 | Some reserved descriptor field is nonzero |
| ent_valid | input | 1 | Map entry valid bit |
| ent_pending | input | 1 | Map entry pending bit |
| ent_modified | input | 1 | Map entry modified bit |
| ent_type | input | TYPE_W | Map entry page type |
| ent_r | input | 1 | Current read permission |
| ent_w | input | 1 | Current write permission |
| ent_x | input | 1 | Current execute permission |
| cont_init | input | 1 | Owning container is initialized |
| page_busy | input | 1 | Another operation holds the page |
| done | output | 1 | Result valid pulse |
| outcome | output | 2 | 0 none, 1 GP, 2 PF, 3 status |
| status | output | ST_W | 0 success, 1 conflict, 2 not modifiable |
| zf | output | 1 | Zero flag result |
| arith_clr | output | 1 | Clear the other arithmetic flags |
| ent_we | output | 1 | Entry write enable |
| ent_wr_r | output | 1 | Written read permission |
| ent_wr_w | output | 1 | Written write permission |
| ent_wr_x | output | 1 | Written execute permission |
| ent_wr_restrict | output | 1 | Written restriction-in-progress bit |

## Verification
Each stimulus row arms one check while keeping every higher-priority check quiet, and paired rows then arm two checks at once, so that the reported outcome shows which of the two ranks higher, for example a busy page that is also pending, or a bad type with an uninitialized container. Success rows use different pairs of old permission and mask values, so a write that copies the mask, keeps the old bits, or ORs them is told apart from the required AND. Directed tests then cover the reset state, the fall of done after its single cycle, and back-to-back requests.

// File: rtl/perm_restrict_unit.sv
module perm_restrict_unit #(
  parameter int ADDR_W     = 48,
  parameter int DESC_ALIGN = 6,
  parameter int PAGE_ALIGN = 12,
  parameter int TYPE_W     = 3,
  parameter int REG_TYPE   = 0,
  parameter int ST_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        priv_lvl,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [ADDR_W-1:0] page_addr,
  input  logic              region_hit,
  input  logic              desc_r,
  input  logic              desc_w,
  input  logic              desc_x,
  input  logic              desc_rsvd_nz,
  input  logic              ent_valid,
  input  logic              ent_pending,
  input  logic              ent_modified,
  input  logic [TYPE_W-1:0] ent_type,
  input  logic              ent_r,
  input  logic              ent_w,
  input  logic              ent_x,
  input  logic              cont_init,
  input  logic              page_busy,
  output logic              done,
  output logic [1:0]        outcome,
  output logic [ST_W-1:0]   status,
  output logic              zf,
  output logic              arith_clr,
  output logic              ent_we,
  output logic              ent_wr_r,
  output logic              ent_wr_w,
  output logic              ent_wr_x,
  output logic              ent_wr_restrict
);

  localparam logic [1:0] OC_NONE = 2'd0;
  localparam logic [1:0] OC_GP   = 2'd1;
  localparam logic [1:0] OC_PF   = 2'd2;
  localparam logic [1:0] OC_ST   = 2'd3;
  localparam logic [ST_W-1:0] ST_OK       = ST_W'(0);
  localparam logic [ST_W-1:0] ST_CONFLICT = ST_W'(1);
  localparam logic [ST_W-1:0] ST_NOMOD    = ST_W'(2);

  wire desc_mis = |desc_addr[DESC_ALIGN-1:0];
  wire page_mis = |page_addr[PAGE_ALIGN-1:0];
  wire bad_desc = desc_rsvd_nz | (~desc_r & desc_w);
  wire bad_type = ent_type != TYPE_W'(REG_TYPE);

  logic [1:0]      nx_oc;
  logic [ST_W-1:0] nx_st;

  always_comb begin
    nx_st = ST_OK;
    if (priv_lvl != 2'd0)              nx_oc = OC_GP;
    else if (desc_mis || page_mis)     nx_oc = OC_GP;
    else if (!region_hit)              nx_oc = OC_PF;
    else if (bad_desc)                 nx_oc = OC_GP;
    else if (!ent_valid)               nx_oc = OC_PF;
    else if (page_busy) begin
      nx_oc = OC_ST;
      nx_st = ST_CONFLICT;
    end else if (ent_pending || ent_modified) begin
      nx_oc = OC_ST;
      nx_st = ST_NOMOD;
    end else if (bad_type)             nx_oc = OC_PF;
    else if (!cont_init)               nx_oc = OC_GP;
    else                               nx_oc = OC_NONE;
  end

  wire nx_ok = nx_oc == OC_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done            <= 1'b0;
      outcome         <= OC_NONE;
      status          <= ST_OK;
      zf              <= 1'b0;
      arith_clr       <= 1'b0;
      ent_we          <= 1'b0;
      ent_wr_r        <= 1'b0;
      ent_wr_w        <= 1'b0;
      ent_wr_x        <= 1'b0;
      ent_wr_restrict <= 1'b0;
    end else begin
      done   <= req_valid;
      ent_we <= req_valid & nx_ok;
      if (req_valid) begin
        outcome         <= nx_oc;
        status          <= nx_st;
        zf              <= nx_oc == OC_ST;
        arith_clr       <= nx_ok | (nx_oc == OC_ST);
        ent_wr_r        <= ent_r & desc_r;
        ent_wr_w        <= ent_w & desc_w;
        ent_wr_x        <= ent_x & desc_x;
        ent_wr_restrict <= nx_ok;
      end
    end
  end

  // R11
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done);

  // R1
  priv_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && priv_lvl != 2'd0) |=> (outcome == OC_GP));

  // R12
  fault_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (outcome == OC_GP || outcome == OC_PF)) |-> (!ent_we && !zf));

  // R6
  soft_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && outcome == OC_ST) |-> (zf && !ent_we && (status == ST_CONFLICT || status == ST_NOMOD)));

  // R9
  no_widen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_we |-> (!(ent_wr_r && !$past(ent_r)) && !(ent_wr_w && !$past(ent_w))
                && !(ent_wr_x && !$past(ent_x)) && ent_wr_restrict && done));

endmodule

// File: tb/perm_restrict_unit_bench.sv
`timescale 1ns/1ps
module perm_restrict_unit_bench;

  localparam int AW = 48;
  localparam logic [AW-1:0] BASE = 48'h0000_1234_5000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, region_hit, desc_r, desc_w, desc_x, desc_rsvd_nz;
  logic ent_valid, ent_pending, ent_modified, ent_r, ent_w, ent_x, cont_init, page_busy;
  logic [1:0] priv_lvl;
  logic [AW-1:0] desc_addr, page_addr;
  logic [2:0] ent_type;
  logic done, zf, arith_clr, ent_we, ent_wr_r, ent_wr_w, ent_wr_x, ent_wr_restrict;
  logic [1:0] outcome;
  logic [7:0] status;

  perm_restrict_unit u_perm_restrict_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .priv_lvl(priv_lvl),
    .desc_addr(desc_addr), .page_addr(page_addr), .region_hit(region_hit),
    .desc_r(desc_r), .desc_w(desc_w), .desc_x(desc_x), .desc_rsvd_nz(desc_rsvd_nz),
    .ent_valid(ent_valid), .ent_pending(ent_pending), .ent_modified(ent_modified),
    .ent_type(ent_type), .ent_r(ent_r), .ent_w(ent_w), .ent_x(ent_x),
    .cont_init(cont_init), .page_busy(page_busy), .done(done), .outcome(outcome),
    .status(status), .zf(zf), .arith_clr(arith_clr), .ent_we(ent_we),
    .ent_wr_r(ent_wr_r), .ent_wr_w(ent_wr_w), .ent_wr_x(ent_wr_x),
    .ent_wr_restrict(ent_wr_restrict)
  );

  typedef struct packed {
    logic [1:0]  cpl;
    logic [11:0] dlo;
    logic [11:0] plo;
    logic        hit;
    logic [3:0]  dfl;   // rsvd, r, w, x
    logic [2:0]  perm;  // r, w, x
    logic [3:0]  est;   // valid, pending, modified, busy
    logic [2:0]  typ;
    logic        init;
    logic [1:0]  oc;
    logic [7:0]  st;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 12'h040, 12'h000, 1'b1, 4'b0101, 3'b111, 4'b1000, 3'd0, 1'b1, 2'd0, 8'd0}, // R9
    '{2'd3, 12'h041, 12'h000, 1'b1, 4'b0101, 3'b111, 4'b1000, 3'd0, 1'b1, 2'd1, 8'd0}, // R1
    '{2'd1, 12'h040, 12'h000, 1'b0, 4'b0101, 3'b111, 4'b0000, 3'd0, 1'b1, 2'd1, 8'd0}, // R1
    '{2'd0, 12'h041, 12'h000, 1'b1, 4'b0101, 3'b111, 4'b1000, 3'd0, 1'b1, 2'd1, 8'd0}, // R2
    '{2'd0, 12'h000, 12'h800, 1'b1, 4'b0101, 3'b111, 4'b1000, 3'd0, 1'b1, 2'd1, 8'd0}, // R2
    '{2'd0, 12'h040, 12'h001, 1'b0, 4'b0101, 3'b111, 4'b1000, 3'd0, 1'b1, 2'd1, 8'd0}, // R2 over R3
    '{2'd0, 12'h040, 12'h000, 1'b0, 4'b0101, 3'b111, 4'b1000, 3'd0, 1'b1, 2'd2, 8'd0}, // R3
    '{2'd0, 12'h040, 12'h000, 1'b0, 4'b1101, 3'b111, 4'b1000, 3'd0, 1'b1, 2'd2, 8'd0}, // R3 over R4
    '{2'd0, 12'h040, 12'h000, 1'b1, 4'b1101, 3'b111, 4'b1000, 3'd0, 1'b1, 2'd1, 8'd0}, // R4
    '{2'd0, 12'h040, 12'h000, 1'b1, 4'b0010, 3'b111, 4'b0000, 3'd0, 1'b1, 2'd1, 8'd0}, // R4 over R5
    '{2'd0, 12'h040, 12'h000, 1'b1, 4'b0101, 3'b111, 4'b0001, 3'd0, 1'b1, 2'd2, 8'd0}, // R5 over R6
    '{2'd0, 12'h040, 12'h000, 1'b1, 4'b0101, 3'b111, 4'b1101, 3'd0, 1'b1, 2'd3, 8'd1}, // R6 over R7
    '{2'd0, 12'h040, 12'h000, 1'b1, 4'b0101, 3'b111, 4'b1001, 3'd2, 1'b0, 2'd3, 8'd1}, // R6
    '{2'd0, 12'h040, 12'h000, 1'b1, 4'b0101, 3'b111, 4'b1100, 3'd0, 1'b1, 2'd3, 8'd2}, // R7
    '{2'd0, 12'h040, 12'h000, 1'b1, 4'b0101, 3'b111, 4'b1010, 3'd1, 1'b1, 2'd3, 8'd2}, // R7 over R8
    '{2'd0, 12'h040, 12'h000, 1'b1, 4'b0101, 3'b111, 4'b1000, 3'd1, 1'b0, 2'd2, 8'd0}, // R8 type
    '{2'd0, 12'h040, 12'h000, 1'b1, 4'b0101, 3'b111, 4'b1000, 3'd0, 1'b0, 2'd1, 8'd0}, // R8 init
    '{2'd0, 12'hFC0, 12'h000, 1'b1, 4'b0111, 3'b010, 4'b1000, 3'd0, 1'b1, 2'd0, 8'd0}, // R9
    '{2'd0, 12'h000, 12'h000, 1'b1, 4'b0000, 3'b101, 4'b1000, 3'd0, 1'b1, 2'd0, 8'd0}, // R9
    '{2'd0, 12'h080, 12'h000, 1'b1, 4'b0110, 3'b011, 4'b1000, 3'd0, 1'b1, 2'd0, 8'd0}  // R9
  };

  int total = 0;
  int bad = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    priv_lvl     = v.cpl;
    desc_addr    = BASE | AW'(v.dlo);
    page_addr    = BASE | AW'(v.plo);
    region_hit   = v.hit;
    {desc_rsvd_nz, desc_r, desc_w, desc_x} = v.dfl;
    {ent_r, ent_w, ent_x} = v.perm;
    {ent_valid, ent_pending, ent_modified, page_busy} = v.est;
    ent_type     = v.typ;
    cont_init    = v.init;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    logic [2:0] exp_wr;
    logic ok;
    @(negedge clk);
    drive(v);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ok = (v.oc == 2'd0);
    exp_wr = v.perm & v.dfl[2:0];
    check($sformatf("R11 done vec%0d", idx), 32'(done), 32'd1);
    check($sformatf("R1-chain outcome vec%0d", idx), 32'(outcome), 32'(v.oc));
    if (v.oc == 2'd3 || ok)
      check($sformatf("R6/R7/R9 status vec%0d", idx), 32'(status), 32'(v.st));
    check($sformatf("R12 zf vec%0d", idx), 32'(zf), 32'(v.oc == 2'd3));
    check($sformatf("R10 arith_clr vec%0d", idx), 32'(arith_clr), 32'(ok || v.oc == 2'd3));
    check($sformatf("R12 ent_we vec%0d", idx), 32'(ent_we), 32'(ok));
    if (ok) begin
      check($sformatf("R9 perms vec%0d", idx), 32'({ent_wr_r, ent_wr_w, ent_wr_x}), 32'(exp_wr));
      check($sformatf("R9 restrict vec%0d", idx), 32'(ent_wr_restrict), 32'd1);
    end
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    drive(VEC[0]);
    repeat (3) @(negedge clk);
    check("R11 reset done", 32'(done), 32'd0);
    check("R11 reset ent_we", 32'(ent_we), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R11: done lasts one cycle
    run_vec(VEC[0], 100);
    @(negedge clk);
    check("R11 done falls", 32'(done), 32'd0);
    check("R11 we falls", 32'(ent_we), 32'd0);

    // R11: back-to-back requests, fault then success
    @(negedge clk);
    drive(VEC[8]);
    req_valid = 1'b1;
    @(negedge clk);
    check("R11 b2b first done", 32'(done), 32'd1);
    check("R4 b2b first outcome", 32'(outcome), 32'd1);
    drive(VEC[17]);
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 b2b second done", 32'(done), 32'd1);
    check("R9 b2b second outcome", 32'(outcome), 32'd0);
    check("R9 b2b perms", 32'({ent_wr_r, ent_wr_w, ent_wr_x}), 32'(3'b010));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule